// File: doc/BRIEF.md
# Two-Wire Target with Sixteen-Bit Register Bank

This block is an I2C target that owns a small bank of sixteen-bit registers, each selected by an eight-bit command byte. The SCL and SDA lines are oversampled by a faster system clock. START and STOP conditions are recovered from the sampled lines, and the block drives SDA open-drain style: it either pulls the line low or leaves it alone. It has its own seven-bit address and also listens to a shared broadcast address. The broadcast address works for writes only.

A write carries the target address with R/W=0, a command byte, then the high data byte and the low data byte. The register changes only once the low byte has been acknowledged. The block then pulses a write strobe towards the core logic, carrying the command and the new word.

A read can take either of two forms. The combined form writes a command byte, issues a repeated START, and then reads two bytes. The shortcut form goes straight to the address with R/W=1 and returns the register most recently written.

Top module: `i2c_reg16_target`

## Requirements
- R1: After reset, `sda_oe` is low. The registers hold these values: command 0xD0 = 0x000C, 0xD1 = 0x01F0, 0xD3 = 0x0008, and 0x21, 0x25, 0x26 = 0x0000.
- R2: The address byte is the seven-bit address followed by the R/W bit in bit 0 (1 = read). The own address (default 0x48) is acknowledged in both directions. Any other address is not acknowledged, and every following byte up to the next START is ignored: none is acknowledged and no register changes.
- R3: A write is address (R/W=0), command, high byte, low byte, and each of these is acknowledged. The register, and a one-cycle `wr_stb` carrying `wr_cmd`/`wr_data`, update only after the low byte is acknowledged. A STOP that comes after the high byte leaves the register unchanged.
- R4: A combined read (address W, command, repeated START, address R) returns the selected register, high byte first, then low byte.
- R5: A read whose address phase has no command byte in the same transaction returns the last fully written register. Before any write, that register is 0xD0.
- R6: The broadcast address (default 0x47) is acknowledged with R/W=0, and writes made through it take effect. With R/W=1 it is not acknowledged, and the target never drives SDA for that read.
- R7: A command byte that matches no register is not acknowledged. A read that follows it in the same transaction returns 0x0000.
- R8: If the controller does not acknowledge the high byte, the target releases SDA and stops sending. After the low byte the target always stops sending, so any further byte reads as 0xFF.
- R9: A START seen during any phase, including inside an address byte, restarts address reception.
- R10: `sda_oe` is asserted only in an acknowledge slot of a byte the target accepts, or while the target sends read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | High pulls SDA low |
| wr_stb | output | 1 | One-cycle pulse when a register is written |
| wr_cmd | output | 8 | Command of the written register |
| wr_data | output | 16 | Word written |

## Verification
The hardest state to reach is a read whose register choice depends on earlier traffic. Three cases matter: a repeated START after a rejected command, a shortcut read after a write that broke off early, and a broadcast read that must stay silent. The bench drives the bus bit by bit so it can stop at any point. It places these sequences one after another, so each read reveals the pointer state left behind by the transaction before it. A START inside an address byte is produced by sending four address bits and then a repeated START.

// File: rtl/i2c_reg16_pkg.sv
// Shared constants and types for the sixteen-bit register target.
// Assumes the register set is fixed at build time; index 0 is the
// default pointer after reset.
package i2c_reg16_pkg;
    localparam int NREG = 6;
    localparam int CW   = 8;
    localparam int DW   = 16;
    localparam logic [NREG*CW-1:0] CMD_CODES =
        {8'h26, 8'h25, 8'h21, 8'hD3, 8'hD1, 8'hD0};
    localparam logic [NREG*DW-1:0] RST_VALS =
        {16'h0000, 16'h0000, 16'h0000, 16'h0008, 16'h01F0, 16'h000C};

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_CMD, ST_DMSB, ST_DLSB,
        ST_ACK, ST_TX, ST_MACK, ST_WAIT
    } state_t;

    typedef enum logic [2:0] {
        NX_CMD, NX_MSB, NX_LSB, NX_COMMIT, NX_TX
    } next_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA into the system clock and derives edge and
// bus-condition strobes. Assumes each SCL phase lasts longer than
// STAGES+1 system clocks.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_d, sda_d;

    // Shift the raw lines through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_reg16_bank.sv
// Register bank addressed by command code. One write port and one read
// port, plus a membership check used when a command byte arrives.
// Unknown codes read as zero.
module i2c_reg16_bank
    import i2c_reg16_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [CW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [CW-1:0] chk_addr,
    output logic          chk_hit
);
    logic [DW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Hold one register; load its reset value or a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= RST_VALS[i*DW +: DW];
            else if (we && waddr == CMD_CODES[i*CW +: CW])
                regs[i] <= wdata;
        end
    end

    // Select the read word and flag whether the checked code exists.
    always_comb begin
        rdata   = '0;
        chk_hit = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (raddr == CMD_CODES[i*CW +: CW])
                rdata = regs[i];
            if (chk_addr == CMD_CODES[i*CW +: CW])
                chk_hit = 1'b1;
        end
    end
endmodule

// File: rtl/i2c_reg16_target.sv
// Two-wire target front end with a sixteen-bit register bank.
// It samples on SCL rise and changes SDA drive on SCL fall, both seen
// through the synchroniser. It does not stretch the clock.
module i2c_reg16_target
    import i2c_reg16_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR   = 7'h48,
    parameter logic [6:0] BCAST_ADDR = 7'h47,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    output logic          wr_stb,
    output logic [CW-1:0] wr_cmd,
    output logic [DW-1:0] wr_data
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    state_t        state;
    next_t         nxt;
    logic [3:0]    bit_cnt;
    logic [7:0]    shreg, tx_q;
    logic [CW-1:0] cmd_q, last_q;
    logic [7:0]    msb_q;
    logic [DW-1:0] rd_word, rdata;
    logic          cmd_fresh, second, mack_ok, chk_hit, addr_ok;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_reg16_bank u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_stb), .waddr(wr_cmd),
        .wdata(wr_data), .raddr(cmd_fresh ? cmd_q : last_q),
        .rdata(rdata), .chk_addr(shreg), .chk_hit(chk_hit)
    );

    // Own address in both directions, broadcast address for writes only.
    assign addr_ok = (shreg[7:1] == TGT_ADDR) ||
                     (shreg[7:1] == BCAST_ADDR && !shreg[0]);

    // Protocol sequencer: byte reception, acknowledge, read-out and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            nxt       <= NX_CMD;
            bit_cnt   <= '0;
            shreg     <= '0;
            tx_q      <= '0;
            cmd_q     <= '0;
            last_q    <= CMD_CODES[CW-1:0];
            msb_q     <= '0;
            rd_word   <= '0;
            cmd_fresh <= 1'b0;
            second    <= 1'b0;
            mack_ok   <= 1'b0;
            sda_oe    <= 1'b0;
            wr_stb    <= 1'b0;
            wr_cmd    <= '0;
            wr_data   <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (stop_det) begin
                state     <= ST_IDLE;
                sda_oe    <= 1'b0;
                cmd_fresh <= 1'b0;
            end else if (start_det) begin
                state   <= ST_ADDR;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_DMSB, ST_DLSB: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            state   <= ST_WAIT;
                            case (state)
                                ST_ADDR: if (addr_ok) begin
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK;
                                    nxt     <= shreg[0] ? NX_TX : NX_CMD;
                                    rd_word <= rdata;
                                    second  <= 1'b0;
                                end
                                ST_CMD: begin
                                    cmd_q     <= shreg;
                                    cmd_fresh <= 1'b1;
                                    if (chk_hit) begin
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                        nxt    <= NX_MSB;
                                    end
                                end
                                ST_DMSB: begin
                                    msb_q  <= shreg;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    nxt    <= NX_LSB;
                                end
                                default: begin
                                    wr_data <= {msb_q, shreg};
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK;
                                    nxt     <= NX_COMMIT;
                                end
                            endcase
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        case (nxt)
                            NX_CMD: state <= ST_CMD;
                            NX_MSB: state <= ST_DMSB;
                            NX_LSB: state <= ST_DLSB;
                            NX_COMMIT: begin
                                wr_stb <= 1'b1;
                                wr_cmd <= cmd_q;
                                last_q <= cmd_q;
                                state  <= ST_WAIT;
                            end
                            default: begin
                                tx_q   <= rd_word[15:8];
                                sda_oe <= ~rd_word[15];
                                state  <= ST_TX;
                            end
                        endcase
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= ST_MACK;
                            end else begin
                                tx_q   <= {tx_q[6:0], 1'b0};
                                sda_oe <= ~tx_q[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack_ok && !second) begin
                                second <= 1'b1;
                                tx_q   <= rd_word[7:0];
                                sda_oe <= ~rd_word[7];
                                state  <= ST_TX;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg16_checker.sv
// Protocol properties for the register target, attached by bind.
// Assumes SCL low phases outlast the synchroniser latency.
module i2c_reg16_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic [7:0] wr_cmd,
    input logic       stop_det
);
    p_release_after_reset_r1: assert property (@(posedge clk)
        disable iff (!rst_n) !$past(rst_n) |-> !sda_oe);

    p_drive_change_scl_low_r10: assert property (@(posedge clk)
        disable iff (!rst_n) !$stable(sda_oe) |-> !scl_in);

    p_stb_single_cycle_r3: assert property (@(posedge clk)
        disable iff (!rst_n) wr_stb |=> !wr_stb);

    p_stb_known_cmd_r7: assert property (@(posedge clk)
        disable iff (!rst_n)
        wr_stb |-> (wr_cmd inside {8'hD0, 8'hD1, 8'hD3, 8'h21, 8'h25, 8'h26}));

    p_stop_releases_r9: assert property (@(posedge clk)
        disable iff (!rst_n) stop_det |=> !sda_oe);
endmodule

bind i2c_reg16_target i2c_reg16_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_cmd(wr_cmd), .stop_det(stop_det)
);

// File: tb/i2c_reg16_target_bench.sv
// Bit-level controller model with a behavioural register image.
module i2c_reg16_target_bench;
    localparam int Q = 8;
    localparam logic [6:0] TA = 7'h48;
    localparam logic [6:0] BA = 7'h47;

    logic clk = 1'b0, rst_n = 1'b0, m_sda = 1'b1, m_scl = 1'b1;
    logic sda_oe, wr_stb, sda_line;
    logic [7:0]  wr_cmd;
    logic [15:0] wr_data;
    int checks = 0, errors = 0, stb_cnt = 0;
    logic drive_ok = 1'b0;
    logic [7:0]  stb_cmd = '0;
    logic [15:0] stb_data = '0;
    logic [15:0] mreg [256];
    logic [7:0]  mlast = 8'hD0;

    assign sda_line = m_sda & ~sda_oe;
    always #5 clk = ~clk;

    i2c_reg16_target u_i2c_reg16_target (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_cmd(wr_cmd), .wr_data(wr_data)
    );

    always @(posedge clk) if (rst_n && wr_stb) begin
        stb_cnt  = stb_cnt + 1;
        stb_cmd  = wr_cmd;
        stb_data = wr_data;
    end

    // R10: outside permitted slots the target must leave SDA alone.
    always @(negedge clk) if (rst_n && !drive_ok) begin
        checks++;
        if (sda_oe) begin
            errors++;
            $display("FAIL R10: sda_oe got 1 expected 0 at %0t", $time);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        drive_ok = 1'b0;
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit last_ok);
        for (int i = 0; i < n; i++) begin
            m_sda = b[7-i]; wq(Q); m_scl = 1'b1; wq(2*Q);
            if (i == n-1 && last_ok) drive_ok = 1'b1;
            m_scl = 1'b0; wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit rd_next, output bit ack);
        drive_ok = 1'b0;
        send_bits(b, 8, 1'b1);
        m_sda = 1'b1; m_scl = 1'b1; wq(Q);
        ack = !sda_line; wq(Q);
        m_scl = 1'b0; wq(Q);
        if (!rd_next) drive_ok = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        drive_ok = 1'b1; m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            m_scl = 1'b1; wq(Q); b[7-i] = sda_line; wq(Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1;
        m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
        if (!give_ack) drive_ok = 1'b0;
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] c,
                          input logic [15:0] d, output bit all_ack);
        bit a0, a1, a2, a3;
        bus_start();
        send_byte({a, 1'b0}, 1'b0, a0); send_byte(c, 1'b0, a1);
        send_byte(d[15:8], 1'b0, a2);   send_byte(d[7:0], 1'b0, a3);
        bus_stop();
        all_ack = a0 & a1 & a2 & a3;
        if (all_ack) begin mreg[c] = d; mlast = c; end
    endtask

    task automatic rd_comb(input logic [7:0] c, output logic [15:0] v, output bit ok);
        bit a0, a1, a2;
        bus_start();
        send_byte({TA, 1'b0}, 1'b0, a0); send_byte(c, 1'b0, a1);
        bus_start();
        send_byte({TA, 1'b1}, 1'b1, a2);
        recv_byte(1'b1, v[15:8]); recv_byte(1'b0, v[7:0]);
        bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic rd_short(output logic [15:0] v, output bit ok);
        bus_start();
        send_byte({TA, 1'b1}, 1'b1, ok);
        recv_byte(1'b1, v[15:8]); recv_byte(1'b0, v[7:0]);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        bit ok, a;
        int base;
        logic [7:0] codes [6] = '{8'hD0, 8'hD1, 8'hD3, 8'h21, 8'h25, 8'h26};
        for (int i = 0; i < 256; i++) mreg[i] = 16'h0000;
        mreg[8'hD0] = 16'h000C; mreg[8'hD1] = 16'h01F0; mreg[8'hD3] = 16'h0008;
        wq(6); rst_n = 1'b1; wq(2);
        chk("R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);
        chk("R1 reset wr_stb", {31'd0, wr_stb}, 32'd0);

        // R5: pointer before any write is 0xD0.
        rd_short(v, ok);
        chk("R5 shortcut before write ack", {31'd0, ok}, 32'd1);
        chk("R5 shortcut before write", {16'd0, v}, {16'd0, mreg[8'hD0]});

        // R1/R4: reset values through combined reads.
        foreach (codes[i]) begin
            rd_comb(codes[i], v, ok);
            chk("R2 own address acked", {31'd0, ok}, 32'd1);
            chk("R1 R4 reset value", {16'd0, v}, {16'd0, mreg[codes[i]]});
        end

        // R3: full write with strobe.
        base = stb_cnt;
        wr_reg(TA, 8'h25, 16'hA55A, ok);
        chk("R3 write acked", {31'd0, ok}, 32'd1);
        chk("R3 one strobe", stb_cnt, base + 1);
        chk("R3 strobe cmd", {24'd0, stb_cmd}, 32'h25);
        chk("R3 strobe data", {16'd0, stb_data}, 32'hA55A);
        rd_comb(8'h25, v, ok);
        chk("R4 readback", {16'd0, v}, 32'hA55A);
        rd_short(v, ok);
        chk("R5 shortcut last written", {16'd0, v}, 32'hA55A);

        // R3: STOP after high byte leaves register unchanged.
        base = stb_cnt;
        bus_start();
        send_byte({TA, 1'b0}, 1'b0, a); send_byte(8'h26, 1'b0, a);
        send_byte(8'h12, 1'b0, a);
        bus_stop();
        chk("R3 no strobe on partial", stb_cnt, base);
        rd_comb(8'h26, v, ok);
        chk("R3 partial write ignored", {16'd0, v}, 32'h0000);
        rd_short(v, ok);
        chk("R5 pointer kept after partial", {16'd0, v}, 32'hA55A);

        wr_reg(TA, 8'hD1, 16'h8001, ok);
        rd_short(v, ok);
        chk("R5 shortcut follows new write", {16'd0, v}, 32'h8001);

        // R2: foreign address ignored to next START.
        base = stb_cnt;
        bus_start();
        send_byte({7'h30, 1'b0}, 1'b0, a);
        chk("R2 foreign address nacked", {31'd0, a}, 32'd0);
        send_byte(8'h21, 1'b0, a);
        chk("R2 following byte nacked", {31'd0, a}, 32'd0);
        send_byte(8'h77, 1'b0, a); send_byte(8'h77, 1'b0, a);
        bus_stop();
        chk("R2 no strobe", stb_cnt, base);
        rd_comb(8'h21, v, ok);
        chk("R2 register untouched", {16'd0, v}, 32'h0000);

        // R6: broadcast write works, broadcast read silent.
        wr_reg(BA, 8'h21, 16'h1234, ok);
        chk("R6 broadcast write acked", {31'd0, ok}, 32'd1);
        rd_comb(8'h21, v, ok);
        chk("R6 broadcast write applied", {16'd0, v}, 32'h1234);
        bus_start();
        send_byte({BA, 1'b1}, 1'b0, a);
        chk("R6 broadcast read nacked", {31'd0, a}, 32'd0);
        drive_ok = 1'b0;
        for (int k = 0; k < 8; k++) begin
            m_scl = 1'b1; wq(Q); b[7-k] = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
        end
        bus_stop();
        chk("R6 broadcast read line idle", {24'd0, b}, 32'hFF);

        // R7: unknown command nacked, then read gives zero.
        bus_start();
        send_byte({TA, 1'b0}, 1'b0, a); send_byte(8'h55, 1'b0, a);
        chk("R7 unknown cmd nacked", {31'd0, a}, 32'd0);
        bus_start();
        send_byte({TA, 1'b1}, 1'b1, a);
        recv_byte(1'b1, v[15:8]); recv_byte(1'b0, v[7:0]);
        bus_stop();
        chk("R7 unknown cmd reads zero", {16'd0, v}, 32'h0000);

        // R8: controller NACK on high byte ends the read.
        bus_start();
        send_byte({TA, 1'b0}, 1'b0, a); send_byte(8'hD1, 1'b0, a);
        bus_start();
        send_byte({TA, 1'b1}, 1'b1, a);
        recv_byte(1'b0, b);
        chk("R8 high byte before nack", {24'd0, b}, 32'h80);
        recv_byte(1'b0, b);
        chk("R8 released after nack", {24'd0, b}, 32'hFF);
        bus_stop();
        bus_start();
        send_byte({TA, 1'b1}, 1'b1, a);
        recv_byte(1'b1, v[15:8]); recv_byte(1'b1, v[7:0]);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R8 two bytes then", {16'd0, v}, 32'h1234);
        chk("R8 third byte idle", {24'd0, b}, 32'hFF);

        // R9: START inside an address byte restarts reception.
        bus_start();
        drive_ok = 1'b0;
        send_bits({TA, 1'b0}, 4, 1'b0);
        wr_reg(TA, 8'hD3, 16'h0F0F, ok);
        chk("R9 write after restart acked", {31'd0, ok}, 32'd1);
        rd_comb(8'hD3, v, ok);
        chk("R9 write after restart applied", {16'd0, v}, 32'h0F0F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule